// File: doc/BRIEF.md
# Pipelined Synchronous Burst Memory Read Path with Single-Cycle Deselect

This block is the selection and read-data side of a pipelined synchronous burst memory. Each clock cycle is either an address-load cycle or a burst-continue cycle. A load is started by one of two active-low address strobes: the processor strobe or the controller strobe. On a load, the block samples three chip enables of mixed polarity and decides whether the device is selected. While the device stays selected, every continue cycle is one more access. An access is a read or a write, as the external write decode reports.

Read data passes through two registers. The first clock edge registers the access. The next edge captures the array word into an output register, and the word is on the bus for the whole cycle after that edge. The bus is driven only while the captured word is valid and the asynchronous output enable is low. If the device is deselected right after a read, the bus still carries that read's word for one cycle and is released at the edge after that. A write access clears the valid flag at once, so the block never drives the bus while write data may be on it.

The address counter, the byte-write decode and the storage array are outside this block. The block reports each accepted load so that an external address block can register the address, and it reports each accepted write.

Top module: `srb_read_path`

## Requirements
- R1: While reset is asserted and after it is released, the device is deselected, the drive enable is low and the bus is not driven until a selecting load is accepted.
- R2: A read accepted at clock edge N places the array word addressed during cycle N on the bus for the cycle that follows edge N+1. While the device is selected, each further continue cycle yields one word per clock.
- R3: The chip enables are sampled only on a load cycle. On a continue cycle (neither strobe accepted), changing them has no effect on selection or on the data stream.
- R4: A low processor strobe is ignored entirely while the primary enable (active low) is high: no load is reported and the burst in progress continues unchanged.
- R5: A load with the active-high secondary enable low, the active-low secondary enable high, or (for a controller load) the primary enable high deselects the device. No access is made until the next selecting load.
- R6: When a deselecting load follows a read at the next edge, the bus carries the read word for the cycle after the deselect edge and goes to high impedance after the single edge that follows.
- R7: The output enable (active low) acts without a clock: high forces the drive enable low at once, and low drives a valid word at once.
- R8: A write access (a controller load, or a selected continue cycle, with the write request low) clears the read-valid flag on that edge. The bus is not driven in the cycle after that edge or in the cycle after the next edge.
- R9: The processor strobe takes priority over the controller strobe, and a processor load is always a read, whatever the write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_proc_n_i | input | 1 | Processor address strobe, active low |
| ads_ctrl_n_i | input | 1 | Controller address strobe, active low |
| wr_req_n_i | input | 1 | Write request from the byte-write decode, active low |
| ce_n_i | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce2_n_i | input | 1 | Secondary chip enable, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| arr_rdata_i | input | DATA_W | Array word at the currently registered address |
| addr_load_o | output | 1 | A load is accepted at the coming edge |
| wr_acc_o | output | 1 | A write access is accepted at the coming edge |
| drv_en_o | output | 1 | Data bus drive enable |
| dq_io | inout | DATA_W | Tri-state data bus |

## Verification
The assertions assume that the strobes, the chip enables and the write request are known and steady around each rising edge. They also assume that the output enable changes only away from an edge, so its level at the edge matches what the drive enable shows after it. The stimulus changes every synchronous input on the falling edge. It toggles the output enable only in the first half of a cycle and restores it before the next sampling point. The array word is supplied by an address register in the bench, which loads on the reported load and steps on its own advance input. This keeps the read data consistent with each accepted access.

// File: rtl/srb_rp_pkg.sv
package srb_rp_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   function automatic logic enables_select(input logic pri_n, input logic sec, input logic sec_n);
      return !pri_n && sec && !sec_n;
   endfunction

endpackage

// File: rtl/srb_rp_sel_decode.sv
module srb_rp_sel_decode
   import srb_rp_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ads_proc_n_i,
   input  logic ads_ctrl_n_i,
   input  logic wr_req_n_i,
   input  logic ce_n_i,
   input  logic ce2_i,
   input  logic ce2_n_i,
   output logic load_o,
   output logic sel_q_o,
   output acc_e acc_o
);

   logic proc_take;
   logic ctrl_take;
   logic sel_next;
   logic is_write;
   logic sel_q;

   // processor strobe only counts with the primary enable low
   assign proc_take = !ads_proc_n_i && !ce_n_i;
   assign ctrl_take = !ads_ctrl_n_i && !proc_take;
   assign load_o    = proc_take || ctrl_take;

   // enables only matter on a load; otherwise the held state applies
   assign sel_next = load_o ? enables_select(ce_n_i, ce2_i, ce2_n_i) : sel_q;

   // a processor load is always a read
   assign is_write = !proc_take && !wr_req_n_i;

   always_comb begin
      acc_o = ACC_NONE;
      if (sel_next) begin
         acc_o = is_write ? ACC_WRITE : ACC_READ;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= 1'b0;
      end else begin
         sel_q <= sel_next;
      end
   end

   assign sel_q_o = sel_q;

endmodule

// File: rtl/srb_rp_out_pipe.sv
module srb_rp_out_pipe
   import srb_rp_pkg::*;
#(
   parameter int DATA_W         = 18,
   parameter bit CLEAR_DATA_RST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  acc_e              acc_i,
   input  logic [DATA_W-1:0] arr_rdata_i,
   output logic              rd_vld_o,
   output logic [DATA_W-1:0] dout_o
);

   logic              acc_rd_q;
   logic              rd_vld_q;
   logic [DATA_W-1:0] dout_q;

   // access stage followed by output stage
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_rd_q <= 1'b0;
         rd_vld_q <= 1'b0;
      end else begin
         acc_rd_q <= (acc_i == ACC_READ);
         rd_vld_q <= acc_rd_q && (acc_i != ACC_WRITE);
      end
   end

   generate
      if (CLEAR_DATA_RST) begin : g_data_rst
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               dout_q <= '0;
            end else if (acc_rd_q) begin
               dout_q <= arr_rdata_i;
            end
         end
      end else begin : g_data_norst
         always_ff @(posedge clk_i) begin
            if (acc_rd_q) begin
               dout_q <= arr_rdata_i;
            end
         end
      end
   endgenerate

   assign rd_vld_o = rd_vld_q;
   assign dout_o   = dout_q;

endmodule

// File: rtl/srb_rp_bus_drive.sv
module srb_rp_bus_drive #(
   parameter int DATA_W = 18,
   parameter int LANE_W = 9
) (
   input  logic              rd_vld_i,
   input  logic              oe_n_i,
   input  logic [DATA_W-1:0] dout_i,
   output logic              drv_en_o,
   inout  wire  [DATA_W-1:0] dq_io
);

   localparam int LANES = DATA_W / LANE_W;

   // output enable gates the drivers with no clock in between
   assign drv_en_o = rd_vld_i && !oe_n_i;

   genvar ln;
   generate
      for (ln = 0; ln < LANES; ln++) begin : g_lane
         assign dq_io[ln*LANE_W +: LANE_W] = drv_en_o ? dout_i[ln*LANE_W +: LANE_W] : {LANE_W{1'bz}};
      end
   endgenerate

endmodule

// File: rtl/srb_read_path.sv
module srb_read_path
   import srb_rp_pkg::*;
#(
   parameter int DATA_W         = 18,
   parameter int LANE_W         = 9,
   parameter bit CLEAR_DATA_RST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ads_proc_n_i,
   input  logic              ads_ctrl_n_i,
   input  logic              wr_req_n_i,
   input  logic              ce_n_i,
   input  logic              ce2_i,
   input  logic              ce2_n_i,
   input  logic              oe_n_i,
   input  logic [DATA_W-1:0] arr_rdata_i,
   output logic              addr_load_o,
   output logic              wr_acc_o,
   output logic              drv_en_o,
   inout  wire  [DATA_W-1:0] dq_io
);

   localparam int LANES = DATA_W / LANE_W;

   initial begin
      assert (LANE_W > 0 && DATA_W % LANE_W == 0)
         else $fatal(1, "DATA_W must be a whole number of lanes");
      assert (LANES >= 1)
         else $fatal(1, "at least one lane is needed");
   end

   acc_e              acc;
   logic              sel_q;
   logic              rd_vld;
   logic              rd_acc_now;
   logic [DATA_W-1:0] dout;

   srb_rp_sel_decode u_dec (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ads_proc_n_i (ads_proc_n_i),
      .ads_ctrl_n_i (ads_ctrl_n_i),
      .wr_req_n_i   (wr_req_n_i),
      .ce_n_i       (ce_n_i),
      .ce2_i        (ce2_i),
      .ce2_n_i      (ce2_n_i),
      .load_o       (addr_load_o),
      .sel_q_o      (sel_q),
      .acc_o        (acc)
   );

   srb_rp_out_pipe #(
      .DATA_W         (DATA_W),
      .CLEAR_DATA_RST (CLEAR_DATA_RST)
   ) u_pipe (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .acc_i       (acc),
      .arr_rdata_i (arr_rdata_i),
      .rd_vld_o    (rd_vld),
      .dout_o      (dout)
   );

   srb_rp_bus_drive #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W)
   ) u_bus (
      .rd_vld_i (rd_vld),
      .oe_n_i   (oe_n_i),
      .dout_i   (dout),
      .drv_en_o (drv_en_o),
      .dq_io    (dq_io)
   );

   assign wr_acc_o   = (acc == ACC_WRITE);
   assign rd_acc_now = (acc == ACC_READ);

endmodule

// File: rtl/srb_read_path_chk.sv
module srb_read_path_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic ads_proc_n_i,
   input logic ads_ctrl_n_i,
   input logic ce_n_i,
   input logic ce2_i,
   input logic ce2_n_i,
   input logic oe_n_i,
   input logic addr_load_o,
   input logic wr_acc_o,
   input logic drv_en_o,
   input logic sel_q,
   input logic rd_acc_now
);

   logic rd_seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_seen_q <= 1'b0;
      end else begin
         rd_seen_q <= rd_acc_now;
      end
   end

   // R7: output enable high keeps the bus released
   a_r7_oe_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_n_i |-> !drv_en_o);

   // R4: processor strobe with primary enable high and no controller strobe loads nothing
   a_r4_proc_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ads_proc_n_i && ce_n_i && ads_ctrl_n_i) |-> !addr_load_o);

   // R5: a deselecting load leaves the bus released two edges on
   a_r5_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_load_o && (ce_n_i || !ce2_i || ce2_n_i)) |=> ##1 !drv_en_o);

   // R8: a write access releases the bus right after its edge
   a_r8_write_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_acc_o |=> !drv_en_o);

   // R2: a read not followed by a write shows up one stage later
   a_r2_read_pipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_seen_q && !wr_acc_o) |=> (drv_en_o == !oe_n_i));

   // R1: an unselected device makes no read access
   a_r1_no_read_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_q && !addr_load_o) |-> !rd_acc_now);

endmodule

bind srb_read_path srb_read_path_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .ads_proc_n_i (ads_proc_n_i),
   .ads_ctrl_n_i (ads_ctrl_n_i),
   .ce_n_i       (ce_n_i),
   .ce2_i        (ce2_i),
   .ce2_n_i      (ce2_n_i),
   .oe_n_i       (oe_n_i),
   .addr_load_o  (addr_load_o),
   .wr_acc_o     (wr_acc_o),
   .drv_en_o     (drv_en_o),
   .sel_q        (sel_q),
   .rd_acc_now   (rd_acc_now)
);

// File: tb/srb_read_path_tb_top.sv
`timescale 1ns/1ps
module srb_read_path_tb_top;

   localparam int W = 18;

   typedef struct {
      int          cyc;
      bit          drv;
      logic [W-1:0] data;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ads_p = 1'b1, ads_c = 1'b1, wr_n = 1'b1;
   logic ce_n = 1'b0, ce2 = 1'b1, ce2n = 1'b0, oe_n = 1'b0, adv_n = 1'b1;
   logic [7:0] ext_addr = '0;
   logic [7:0] aq;
   logic [W-1:0] mem [256];
   logic [W-1:0] rdata;
   logic addr_load, wr_acc, drv_en;
   wire  [W-1:0] dq_w;

   int cycnt = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;
   always @(posedge clk) cycnt <= cycnt + 1;

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = W'((i * 613 + 91) ^ (i << 9));
   end

   // bench-side address block and storage array
   always_ff @(posedge clk) begin
      if (addr_load) aq <= ext_addr;
      else if (!adv_n) aq <= aq + 8'd1;
   end
   assign rdata = mem[aq];

   srb_read_path dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ads_proc_n_i(ads_p), .ads_ctrl_n_i(ads_c),
      .wr_req_n_i(wr_n), .ce_n_i(ce_n), .ce2_i(ce2), .ce2_n_i(ce2n), .oe_n_i(oe_n),
      .arr_rdata_i(rdata), .addr_load_o(addr_load), .wr_acc_o(wr_acc),
      .drv_en_o(drv_en), .dq_io(dq_w)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // driver: one cycle of inputs, and what the bus must show two edges later
   task automatic op(input bit p, input bit c, input bit wn, input bit cen, input bit c2,
                     input bit c2n, input bit advn, input int addr,
                     input bit ed, input int ea, input string tag);
      exp_t e;
      @(negedge clk);
      ads_p = p; ads_c = c; wr_n = wn; ce_n = cen; ce2 = c2; ce2n = c2n;
      adv_n = advn; ext_addr = 8'(addr);
      e.cyc = cycnt + 2; e.drv = ed; e.data = mem[ea]; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compares late in each cycle, away from both edges
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (sb.size() > 0 && sb[0].cyc <= cycnt) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.cyc == cycnt, e.tag, "cycle", cycnt, e.cyc);
            chk(drv_en == e.drv, e.tag, "drive", int'(drv_en), int'(e.drv));
            if (e.drv) chk(dq_w == e.data, e.tag, "data", int'(dq_w), int'(e.data));
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(drv_en == 1'b0, "R1", "drive in reset", int'(drv_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(drv_en == 1'b0, "R1", "drive after reset", int'(drv_en), 0);
      op(1,1,1, 0,1,0, 1, 0, 0,0, "R1");

      // R2 burst and R6 single-cycle deselect
      op(1,0,1, 0,1,0, 1, 5, 1,5, "R2");
      op(1,1,1, 0,1,0, 0, 0, 1,6, "R2");
      op(1,1,1, 0,1,0, 0, 0, 1,7, "R6");
      op(1,0,1, 0,0,0, 1, 0, 0,0, "R6");
      op(1,1,1, 0,1,0, 1, 0, 0,0, "R6");

      // R3 enables ignored on continue, R4 processor strobe ignored
      op(1,0,1, 0,1,0, 1, 20, 1,20, "R2");
      op(1,1,1, 1,0,1, 0, 0, 1,21, "R3");
      op(0,1,1, 1,1,0, 0, 99, 1,22, "R4");
      #1;
      chk(addr_load == 1'b0, "R4", "load while selected", int'(addr_load), 0);
      op(1,0,1, 0,1,1, 1, 0, 0,0, "R5");
      op(1,1,1, 0,1,0, 1, 0, 0,0, "R5");
      op(0,1,1, 1,1,0, 1, 0, 0,0, "R4");
      #1;
      chk(addr_load == 1'b0, "R4", "load while deselected", int'(addr_load), 0);

      // R5 controller load with primary enable high
      op(1,0,1, 0,1,0, 1, 30, 1,30, "R5");
      op(1,0,1, 1,1,0, 1, 0, 0,0, "R5");
      op(1,1,1, 0,1,0, 1, 0, 0,0, "R5");

      // R8 writes release the bus
      op(1,0,1, 0,1,0, 1, 40, 0,0, "R8");
      op(1,1,0, 0,1,0, 1, 0, 0,0, "R8");
      op(1,1,1, 0,1,0, 1, 0, 1,40, "R8");
      op(1,1,1, 0,1,0, 1, 0, 0,0, "R8");
      op(1,0,0, 0,1,0, 1, 50, 0,0, "R8");
      op(1,1,1, 0,1,0, 1, 0, 1,50, "R8");
      op(1,0,1, 0,0,0, 1, 0, 0,0, "R5");

      // R9 processor priority and read regardless of write request
      op(0,0,0, 0,1,0, 1, 60, 1,60, "R9");
      op(0,1,1, 0,0,0, 1, 0, 0,0, "R5");
      op(1,1,1, 0,1,0, 1, 0, 0,0, "R5");

      // R7 asynchronous output enable
      op(1,0,1, 0,1,0, 1, 70, 1,70, "R2");
      op(1,1,1, 0,1,0, 1, 0, 1,70, "R2");
      op(1,1,1, 0,1,0, 1, 0, 1,70, "R2");
      op(1,1,1, 0,1,0, 1, 0, 1,70, "R2");
      @(posedge clk);
      #1 oe_n = 1'b1;
      #1 chk(drv_en == 1'b0, "R7", "drive with oe high", int'(drv_en), 0);
      #1 oe_n = 1'b0;
      #1 chk(drv_en == 1'b1, "R7", "drive with oe low", int'(drv_en), 1);
      chk(dq_w == mem[70], "R7", "data with oe low", int'(dq_w), int'(mem[70]));
      op(1,0,1, 0,0,0, 1, 0, 0,0, "R6");
      op(1,1,1, 0,1,0, 1, 0, 0,0, "R6");

      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule